// File: doc/BRIEF.md
# Serial Idle-Locked Stream Descrambler

This block recovers a plain bit stream from a scrambled serial line, taking one bit per clock. A local 11-bit linear feedback shift register produces a key stream. Each incoming bit is XORed with the current key bit. The block finds the transmitter's key position without any side channel. It assumes that the line carries scrambled idle, which is all ones before scrambling. Under that assumption, every scrambled bit XORed with one is a key bit, and the block shifts that value into its register. Once enough consecutive descrambled ones confirm that the guess is right, the register runs freely and the block reports lock.

While locked, a line-state monitor watches the descrambled output for long runs of ones. A hold timer counts down a window of configurable length. Each long enough run of ones restarts the window. If the window runs out first, the block drops lock and clears its key register and counters. It then starts acquisition again from a clean state.

The output is a serial stream with no code-group boundary implied. Each descrambled bit appears one clock after its input bit, together with a valid flag that is high while the block was locked.

Top module: `idle_lock_descrambler`

## Requirements
- R1: While reset is held and in the first cycle after it, `lockOut` and `validOut` are 0.
- R2: The key bit is `key[10] ^ key[8]` of an 11-bit register (polynomial x^11 + x^9 + 1). The descrambled bit is `sdIn ^ keybit`. When locked, the register shifts the key bit in at bit 0, so a matching transmitter's plain bits are reproduced exactly.
- R3: During acquisition the register shifts in `~sdIn`, which is the scrambled bit XORed with an assumed 1. After 11 idle bits it therefore matches the transmitter.
- R4: Lock is declared at the clock that consumes the 60th consecutive descrambled 1 in acquisition. Lock is never declared earlier, and from a cleared state it is declared within 71 idle bits.
- R5: A descrambled 0 during acquisition restarts the count of 60.
- R6: `outBit` is the descrambled value of the `sdIn` sampled at the previous clock. `validOut` equals the value `lockOut` had one clock earlier.
- R7: While locked, the clock that consumes the 58th consecutive descrambled 1 restarts the hold window and also restarts the run count.
- R8: If HOLD_CYCLES clocks pass after lock or after the last restart with no restart, `lockOut` falls at that clock and `validOut` falls one clock later.
- R9: On loss of lock the key register and all counters are cleared, so a new lock needs a further 60 consecutive descrambled ones.
- R10: Runs of 57 ones separated by a 0 never restart the hold window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sdIn | input | 1 | Scrambled serial input bit |
| outBit | output | 1 | Descrambled bit, one clock after its input |
| validOut | output | 1 | `outBit` was produced while locked |
| lockOut | output | 1 | Descrambler is locked |

## Verification
The bench drives a reference scrambler started from a nonzero seed. It checks that lock never appears after only 59 idle bits, both after a 0 in the middle of acquisition and after a loss of lock. A design that kept its run count across that 0, or kept a stale key register, would lock too early. The bench also checks that lock does appear by bit 71, which would catch a wrong tap or a seeding error. The hold window is tested at its exact boundary: lock must still be present HOLD_CYCLES-1 clocks after a 58-one run and gone at the next clock. During that window, runs of 57 ones are fed in, so a monitor that is off by one in its threshold would keep lock. Random data between idle bursts is compared bit by bit to catch any key misalignment after lock.

// File: rtl/descr_pkg.sv
package descr_pkg;
  typedef struct packed {
    logic seedMode;  // shift assumed-idle key into register
    logic clearKey;  // wipe key register (loss of lock)
    logic emit;      // produced bit is valid
  } descr_ctrl_t;
endpackage

// File: rtl/descr_datapath.sv
module descr_datapath
  import descr_pkg::*;
#(
  parameter int LFSR_W  = 11,
  parameter int MID_TAP = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdIn,
  input  descr_ctrl_t       ctrl,
  output logic              descBit,
  output logic              outBit,
  output logic              outValid,
  output logic [LFSR_W-1:0] keyState
);
  localparam int HI_TAP = LFSR_W - 1;
  localparam int LO_TAP = MID_TAP - 1;

  logic keyBit;
  logic [LFSR_W-1:0] keyNext;

  assign keyBit  = keyState[HI_TAP] ^ keyState[LO_TAP];
  assign descBit = sdIn ^ keyBit;

  always_comb begin
    if (ctrl.clearKey)
      keyNext = '0;
    else if (ctrl.seedMode)
      keyNext = {keyState[LFSR_W-2:0], ~sdIn};
    else
      keyNext = {keyState[LFSR_W-2:0], keyBit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keyState <= '0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      keyState <= keyNext;
      outBit   <= descBit;
      outValid <= ctrl.emit;
    end
  end
endmodule

// File: rtl/descr_control.sv
module descr_control
  import descr_pkg::*;
#(
  parameter int ACQ_RUN     = 60,
  parameter int HOLD_RUN    = 58,
  parameter int HOLD_CYCLES = 90250
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        descBit,
  output descr_ctrl_t ctrl,
  output logic        locked
);
  localparam int RUN_MAX = (ACQ_RUN > HOLD_RUN) ? ACQ_RUN : HOLD_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int HOLD_W  = $clog2(HOLD_CYCLES + 1);

  typedef enum logic {ST_ACQ, ST_LOCK} state_t;

  state_t            state;
  logic [RUN_W-1:0]  runCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              refresh;
  logic              expire;

  assign refresh = (state == ST_LOCK) && descBit && (runCnt == RUN_W'(HOLD_RUN - 1));
  assign expire  = (state == ST_LOCK) && !refresh && (holdCnt == HOLD_W'(HOLD_CYCLES - 1));

  always_comb begin
    ctrl.seedMode = (state == ST_ACQ);
    ctrl.clearKey = expire;
    ctrl.emit     = (state == ST_LOCK);
  end
  assign locked = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_ACQ;
      runCnt  <= '0;
      holdCnt <= '0;
    end else if (state == ST_ACQ) begin
      holdCnt <= '0;
      if (!descBit) begin
        runCnt <= '0;
      end else if (runCnt == RUN_W'(ACQ_RUN - 1)) begin
        state  <= ST_LOCK;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      if (refresh) begin
        holdCnt <= '0;
        runCnt  <= '0;
      end else if (expire) begin
        state   <= ST_ACQ;
        holdCnt <= '0;
        runCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
        runCnt  <= descBit ? runCnt + 1'b1 : '0;
      end
    end
  end
endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler
  import descr_pkg::*;
#(
  parameter int LFSR_W      = 11,
  parameter int MID_TAP     = 9,
  parameter int ACQ_RUN     = 60,
  parameter int HOLD_RUN    = 58,
  parameter int HOLD_CYCLES = 90250
) (
  input  logic clk,
  input  logic rst,
  input  logic sdIn,
  output logic outBit,
  output logic validOut,
  output logic lockOut
);
  descr_ctrl_t       ctrlW;
  logic              descBitW;
  logic [LFSR_W-1:0] keyStateW;

  descr_control #(
    .ACQ_RUN(ACQ_RUN), .HOLD_RUN(HOLD_RUN), .HOLD_CYCLES(HOLD_CYCLES)
  ) uCtrl (
    .clk(clk), .rst(rst), .descBit(descBitW), .ctrl(ctrlW), .locked(lockOut)
  );

  descr_datapath #(
    .LFSR_W(LFSR_W), .MID_TAP(MID_TAP)
  ) uDp (
    .clk(clk), .rst(rst), .sdIn(sdIn), .ctrl(ctrlW), .descBit(descBitW),
    .outBit(outBit), .outValid(validOut), .keyState(keyStateW)
  );
endmodule

// File: rtl/idle_lock_descrambler_checker.sv
module idle_lock_descrambler_checker #(
  parameter int LFSR_W      = 11,
  parameter int ACQ_RUN     = 60,
  parameter int HOLD_CYCLES = 90250
) (
  input logic              clk,
  input logic              rst,
  input logic              validOut,
  input logic              lockOut,
  input logic [LFSR_W-1:0] keyState
);
  localparam int CNT_MAX = (ACQ_RUN > HOLD_CYCLES) ? ACQ_RUN : HOLD_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);

  logic [CNT_W-1:0] unlockedCnt;
  logic [CNT_W-1:0] lockedCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlockedCnt <= '0;
      lockedCnt   <= '0;
    end else begin
      if (lockOut) unlockedCnt <= '0;
      else if (unlockedCnt != CNT_W'(CNT_MAX)) unlockedCnt <= unlockedCnt + 1'b1;
      if (!lockOut) lockedCnt <= '0;
      else if (lockedCnt != CNT_W'(CNT_MAX)) lockedCnt <= lockedCnt + 1'b1;
    end
  end

  p_valid_lags_lock_r6: assert property (@(posedge clk) disable iff (rst)
    validOut |-> $past(lockOut));

  p_lock_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOut) |-> ($past(unlockedCnt) >= CNT_W'(ACQ_RUN - 1)));

  p_no_early_expiry_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |-> ($past(lockedCnt) >= CNT_W'(HOLD_CYCLES - 1)));

  p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |=> !validOut);

  p_key_cleared_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOut) |-> (keyState == '0));

  always_ff @(posedge clk) begin
    if (rst) p_reset_outputs_r1: assert (!lockOut);
  end
endmodule

bind idle_lock_descrambler idle_lock_descrambler_checker #(
  .LFSR_W(LFSR_W), .ACQ_RUN(ACQ_RUN), .HOLD_CYCLES(HOLD_CYCLES)
) uChk (
  .clk(clk), .rst(rst), .validOut(validOut), .lockOut(lockOut), .keyState(keyStateW)
);

// File: tb/idle_lock_descrambler_test.sv
module idle_lock_descrambler_test;
  localparam int HOLD = 200;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdIn = 1'b0;
  logic outBit, validOut, lockOut;

  int checks = 0;
  int errors = 0;
  logic [10:0] txState = 11'h5A3;

  always #(CLK_NS/2) clk = ~clk;

  idle_lock_descrambler #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .sdIn(sdIn),
    .outBit(outBit), .validOut(validOut), .lockOut(lockOut)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, actual, expected, $time);
    end
  endtask

  // Scramble one plain bit, drive it, let one clock pass, return at negedge.
  task automatic sendBit(input logic ud);
    logic k;
    k = txState[10] ^ txState[8];
    sdIn = ud ^ k;
    txState = {txState[9:0], k};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 lock in reset", lockOut, 1'b0);
    check("R1 valid in reset", validOut, 1'b0);
    rst = 1'b0;
    sendBit(1'b1);
    check("R1 lock after reset", lockOut, 1'b0);
    check("R1 valid after reset", validOut, 1'b0);
  endtask

  task automatic testInterrupted();
    for (int i = 0; i < 39; i++) sendBit(1'b1);
    sendBit(1'b0);
    check("R5 no lock before zero", lockOut, 1'b0);
    for (int i = 0; i < 59; i++) sendBit(1'b1);
    check("R5 count restarted by zero", lockOut, 1'b0);
    for (int i = 0; i < 12; i++) sendBit(1'b1);
    check("R3 R4 lock reached after seeding", lockOut, 1'b1);
    sendBit(1'b1);
    check("R6 valid follows lock", validOut, 1'b1);
  endtask

  task automatic testRecover();
    logic ud;
    int bad = 0;
    for (int rep = 0; rep < 3; rep++) begin
      for (int i = 0; i < 160; i++) begin
        ud = (i < 60) ? 1'b1 : 1'($urandom);
        sendBit(ud);
        if (outBit !== ud || validOut !== 1'b1) bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R2 recovery: actual %0d bad bits expected 0", bad);
    end
    check("R7 lock held across refreshes", lockOut, 1'b1);
  endtask

  task automatic testHoldExpire();
    sendBit(1'b0);
    for (int i = 0; i < 58; i++) sendBit(1'b1);
    for (int i = 0; i < HOLD - 1; i++) sendBit((i % 58) != 57);
    check("R10 lock kept at window edge", lockOut, 1'b1);
    sendBit(((HOLD - 1) % 58) != 57);
    check("R8 lock lost at expiry", lockOut, 1'b0);
    check("R6 valid lags loss", validOut, 1'b1);
    sendBit(1'b1);
    check("R8 valid low after loss", validOut, 1'b0);
  endtask

  task automatic testReacquire();
    for (int i = 0; i < 58; i++) sendBit(1'b1);
    check("R9 no early relock", lockOut, 1'b0);
    for (int i = 0; i < 12; i++) sendBit(1'b1);
    check("R9 relock after clear", lockOut, 1'b1);
    sendBit(1'b0);
    check("R2 data after relock", outBit, 1'b0);
  endtask

  initial begin
    testReset();
    testInterrupted();
    testRecover();
    testHoldExpire();
    testReacquire();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule